// File: doc/BRIEF.md
# Six-Button Gamepad Select-Line Multiplexer

This block produces the byte a host reads from a controller port when a twelve-button gamepad sits behind it. The pad has only seven data lines, so one of them, the select line (TH, bit 6 of the port data register), decides which group of buttons shows on the rest. The host writes the data register and a direction register over a simple byte bus. The read value is built from the current button state, the select level and a small phase counter.

In six-button mode, every host write that moves the select bit from 0 to 1 advances the phase counter. Later phases replace the normal pattern with an identification code and then with the extra buttons (X, Y, Z, Mode). If no advancing write arrives within a programmable number of clock edges, the counter falls back to phase 0. In three-button mode the phase stays at 0, and the pad always reads with the plain two-group encoding.

Bits that the direction register marks as outputs read back the value held in the data register. Bit 7 always reads the data register's bit 7.

Top module: `pad_th_mux`

## Requirements
- R1: Reset clears the data register, the direction register, the phase and the idle count. With no button pressed, the first read after reset is 8'h33.
- R2: `btn_pressed` is active high, indexed 0 Up, 1 Down, 2 Left, 3 Right, 4 B, 5 C, 6 A, 7 Start, 8 Z, 9 Y, 10 X, 11 Mode. A pressed button reads as 0 in the byte and a released button reads as 1.
- R3: On a clock edge with `wr_en` high, `wr_sel`=0 loads `wr_data` into the data register and `wr_sel`=1 loads it into the direction register. The read byte reflects the new value after that edge.
- R4: The phase advances by one only on a data-register write that takes bit 6 from 0 to 1 while `six_btn_en` is high. After phase 3 it wraps to 0. Any other write leaves the phase unchanged.
- R5: With the select bit high in phase 0, 1 or 2, bits 6:0 read select(1), C, B, Right, Left, Down, Up.
- R6: With the select bit low in phase 0 or 1, bit 6 reads 0, bits 5:4 read Start, A, bits 3:2 read 00 and bits 1:0 read Down, Up.
- R7: In phase 2 with the select bit low, bits 5:4 read Start, A and bits 3:0 read 0000.
- R8: In phase 3 with the select bit high, bits 5:4 read C, B and bits 3:0 read Mode, X, Y, Z (bit 3 down to bit 0).
- R9: In phase 3 with the select bit low, bits 5:4 read Start, A and bits 3:0 read 1111.
- R10: Each bit set in the direction register ORs the matching data-register bit into the read byte. Bit 7 always equals data-register bit 7.
- R11: When the phase is non-zero and no advancing write occurs, the phase returns to 0 at the (`idle_limit`+1)th clock edge after the last advance.
- R12: While `six_btn_en` is low, the phase is cleared at the next edge and every read uses the R5/R6 encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| six_btn_en | input | 1 | 1 selects six-button mode, 0 selects three-button mode |
| idle_limit | input | 8 | Idle edges allowed before the phase times out |
| btn_pressed | input | 12 | Button state, 1 = pressed (order in R2) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = data register, 1 = direction register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Port read byte |

## Verification
A directed walk of select-bit toggles runs the phase through 0 to 3 and back. Each step distinguishes the normal, identification, extended and all-ones patterns, and a single pressed button shows whether each bit sits in the right field. Extra cases cover:
- repeated high writes that must not advance the phase;
- three-button mode, where toggling must leave the encoding plain;
- a short idle limit, which separates a timeout from a hold by the exact edge on which the identification pattern disappears.

A long seeded random mix of data writes, direction writes, idle cycles, button changes and rare mode drops then compares every read against a bench model. This exercises the OR-in of output bits together with phase wrap and timeout.

// File: rtl/pad_th_pkg.sv
package pad_th_pkg;
   localparam int BTN_N   = 12;
   localparam int B_UP    = 0;
   localparam int B_DOWN  = 1;
   localparam int B_LEFT  = 2;
   localparam int B_RIGHT = 3;
   localparam int B_B     = 4;
   localparam int B_C     = 5;
   localparam int B_A     = 6;
   localparam int B_START = 7;
   localparam int B_Z     = 8;
   localparam int B_Y     = 9;
   localparam int B_X     = 10;
   localparam int B_MODE  = 11;

   typedef enum logic [2:0] {
      ENC_NORM_HI,
      ENC_NORM_LO,
      ENC_ID_LO,
      ENC_EXT_HI,
      ENC_EXT_LO
   } pad_enc_e;
endpackage

// File: rtl/pad_port_regs.sv
module pad_port_regs #(
   parameter int BUS_W  = 8,
   parameter int TH_BIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] data_q,
   output logic [BUS_W-1:0] dir_q,
   output logic             th_rise
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else if (wr_en) begin
         if (wr_sel) dir_q  <= wr_data;
         else        data_q <= wr_data;
      end
   end

   // a data write that lifts the select bit from low to high
   assign th_rise = wr_en && !wr_sel && !data_q[TH_BIT] && wr_data[TH_BIT];
endmodule

// File: rtl/pad_phase_ctrl.sv
module pad_phase_ctrl #(
   parameter int PHASE_LAST     = 3,
   parameter int PHASE_SATURATE = 0,
   parameter int IDLE_W         = 8,
   localparam int PHASE_W       = $clog2(PHASE_LAST + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               six_en,
   input  logic               th_rise,
   input  logic [IDLE_W-1:0]  idle_limit,
   output logic [PHASE_W-1:0] phase,
   output logic [IDLE_W-1:0]  idle_cnt
);
   localparam logic [PHASE_W-1:0] LAST_V = PHASE_W'(PHASE_LAST);

   logic [PHASE_W-1:0] phase_nxt;

   generate
      if (PHASE_SATURATE != 0) begin : g_sat
         assign phase_nxt = (phase == LAST_V) ? phase : phase + 1'b1;
      end else begin : g_wrap
         assign phase_nxt = (phase == LAST_V) ? '0 : phase + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         idle_cnt <= '0;
      end else if (!six_en) begin
         phase    <= '0;
         idle_cnt <= '0;
      end else if (th_rise) begin
         phase    <= phase_nxt;
         idle_cnt <= '0;
      end else if (phase == '0) begin
         idle_cnt <= '0;
      end else if (idle_cnt == idle_limit) begin
         phase    <= '0;
         idle_cnt <= '0;
      end else begin
         idle_cnt <= idle_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pad_read_mux.sv
module pad_read_mux
   import pad_th_pkg::*;
#(
   parameter int BUS_W      = 8,
   parameter int TH_BIT     = 6,
   parameter int PHASE_LAST = 3,
   localparam int PHASE_W   = $clog2(PHASE_LAST + 1)
) (
   input  logic [BTN_N-1:0]   btn_pressed,
   input  logic [BUS_W-1:0]   data_q,
   input  logic [BUS_W-1:0]   dir_q,
   input  logic [PHASE_W-1:0] phase,
   input  logic               six_en,
   output logic [BUS_W-1:0]   rd_data
);
   localparam logic [PHASE_W-1:0] ID_PH  = PHASE_W'(PHASE_LAST - 1);
   localparam logic [PHASE_W-1:0] EXT_PH = PHASE_W'(PHASE_LAST);

   logic [BTN_N-1:0] n;
   logic             th;
   pad_enc_e         enc;
   logic [BUS_W-1:0] pat;
   logic [BUS_W-1:0] ored;

   assign n  = ~btn_pressed;
   assign th = data_q[TH_BIT];

   always_comb begin
      if (six_en && phase == EXT_PH) enc = th ? ENC_EXT_HI : ENC_EXT_LO;
      else if (six_en && phase == ID_PH && !th) enc = ENC_ID_LO;
      else enc = th ? ENC_NORM_HI : ENC_NORM_LO;
   end

   always_comb begin
      pat         = '0;
      pat[TH_BIT] = th;
      unique case (enc)
         ENC_NORM_HI: pat[5:0] = {n[B_C], n[B_B], n[B_RIGHT], n[B_LEFT], n[B_DOWN], n[B_UP]};
         ENC_NORM_LO: pat[5:0] = {n[B_START], n[B_A], 2'b00, n[B_DOWN], n[B_UP]};
         ENC_ID_LO:   pat[5:0] = {n[B_START], n[B_A], 4'b0000};
         ENC_EXT_HI:  pat[5:0] = {n[B_C], n[B_B], n[B_MODE], n[B_X], n[B_Y], n[B_Z]};
         ENC_EXT_LO:  pat[5:0] = {n[B_START], n[B_A], 4'b1111};
         default:     pat[5:0] = '0;
      endcase
   end

   assign ored    = pat | (data_q & dir_q);
   assign rd_data = {data_q[BUS_W-1] | ored[BUS_W-1], ored[BUS_W-2:0]};
endmodule

// File: rtl/pad_th_mux.sv
module pad_th_mux
   import pad_th_pkg::*;
#(
   parameter int BUS_W          = 8,
   parameter int TH_BIT         = 6,
   parameter int IDLE_W         = 8,
   parameter int PHASE_LAST     = 3,
   parameter int PHASE_SATURATE = 0,
   localparam int PHASE_W       = $clog2(PHASE_LAST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              six_btn_en,
   input  logic [IDLE_W-1:0] idle_limit,
   input  logic [BTN_N-1:0]  btn_pressed,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [BUS_W-1:0]  rd_data
);
   generate
      if (BUS_W != 8)      begin : g_bad_bus   $error("pad_th_mux: BUS_W must be 8"); end
      if (TH_BIT != 6)     begin : g_bad_th    $error("pad_th_mux: TH_BIT must be 6"); end
      if (PHASE_LAST < 2)  begin : g_bad_phase $error("pad_th_mux: PHASE_LAST must be >= 2"); end
      if (IDLE_W < 1)      begin : g_bad_idle  $error("pad_th_mux: IDLE_W must be >= 1"); end
   endgenerate

   logic [BUS_W-1:0]   data_q;
   logic [BUS_W-1:0]   dir_q;
   logic               th_rise;
   logic [PHASE_W-1:0] phase;
   logic [IDLE_W-1:0]  idle_cnt;

   pad_port_regs #(.BUS_W(BUS_W), .TH_BIT(TH_BIT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .data_q  (data_q),
      .dir_q   (dir_q),
      .th_rise (th_rise)
   );

   pad_phase_ctrl #(
      .PHASE_LAST(PHASE_LAST), .PHASE_SATURATE(PHASE_SATURATE), .IDLE_W(IDLE_W)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .six_en     (six_btn_en),
      .th_rise    (th_rise),
      .idle_limit (idle_limit),
      .phase      (phase),
      .idle_cnt   (idle_cnt)
   );

   pad_read_mux #(.BUS_W(BUS_W), .TH_BIT(TH_BIT), .PHASE_LAST(PHASE_LAST)) u_mux (
      .btn_pressed (btn_pressed),
      .data_q      (data_q),
      .dir_q       (dir_q),
      .phase       (phase),
      .six_en      (six_btn_en),
      .rd_data     (rd_data)
   );
endmodule

// File: rtl/pad_th_mux_chk.sv
module pad_th_mux_chk #(
   parameter int BUS_W          = 8,
   parameter int IDLE_W         = 8,
   parameter int PHASE_LAST     = 3,
   parameter int PHASE_SATURATE = 0,
   localparam int PHASE_W       = $clog2(PHASE_LAST + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               six_btn_en,
   input logic [IDLE_W-1:0]  idle_limit,
   input logic [BUS_W-1:0]   rd_data,
   input logic [BUS_W-1:0]   data_q,
   input logic [BUS_W-1:0]   dir_q,
   input logic               th_rise,
   input logic [PHASE_W-1:0] phase,
   input logic [IDLE_W-1:0]  idle_cnt
);
   localparam logic [PHASE_W-1:0] LAST_V = PHASE_W'(PHASE_LAST);

   p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (six_btn_en && th_rise) |=>
         phase == (($past(phase) == LAST_V) ? ((PHASE_SATURATE != 0) ? LAST_V : '0)
                                            : $past(phase) + 1'b1));

   p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (six_btn_en && !th_rise && idle_cnt != idle_limit) |=> $stable(phase));

   p_idle_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (six_btn_en && !th_rise && phase != '0 && idle_cnt == idle_limit) |=> phase == '0);

   p_three_btn_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !six_btn_en |=> phase == '0);

   p_bit7_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BUS_W-1] == data_q[BUS_W-1]);

   p_out_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_q & dir_q) & ~rd_data) == '0);
endmodule

bind pad_th_mux pad_th_mux_chk #(
   .BUS_W(BUS_W), .IDLE_W(IDLE_W), .PHASE_LAST(PHASE_LAST), .PHASE_SATURATE(PHASE_SATURATE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .six_btn_en (six_btn_en),
   .idle_limit (idle_limit),
   .rd_data    (rd_data),
   .data_q     (data_q),
   .dir_q      (dir_q),
   .th_rise    (th_rise),
   .phase      (phase),
   .idle_cnt   (idle_cnt)
);

// File: tb/pad_th_mux_bench.sv
module pad_th_mux_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        six_btn_en = 1'b0;
   logic [7:0]  idle_limit = 8'd200;
   logic [11:0] btn_pressed = '0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] m_data = '0;
   logic [7:0] m_dir  = '0;
   int         m_phase = 0;
   int         m_idle  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pad_th_mux u_pad_th_mux (
      .clk         (clk),
      .rst_n       (rst_n),
      .six_btn_en  (six_btn_en),
      .idle_limit  (idle_limit),
      .btn_pressed (btn_pressed),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .rd_data     (rd_data)
   );

   function automatic logic [7:0] exp_read(int ph, logic [7:0] d, logic [7:0] dr,
                                           logic [11:0] b, logic six);
      logic [11:0] n;
      logic [7:0]  p;
      n    = ~b;
      p    = '0;
      p[6] = d[6];
      if (six && ph == 3 && d[6])       p[5:0] = {n[5], n[4], n[11], n[10], n[9], n[8]};
      else if (six && ph == 3)          p[5:0] = {n[7], n[6], 4'b1111};
      else if (six && ph == 2 && !d[6]) p[5:0] = {n[7], n[6], 4'b0000};
      else if (d[6])                    p[5:0] = {n[5], n[4], n[3], n[2], n[1], n[0]};
      else                              p[5:0] = {n[7], n[6], 2'b00, n[1], n[0]};
      p    = p | (d & dr);
      p[7] = d[7];
      return p;
   endfunction

   function automatic string auto_tag(int ph, logic [7:0] d, logic six);
      if (!six) return "R12";
      if (ph == 3) return d[6] ? "R8" : "R9";
      if (ph == 2 && !d[6]) return "R7";
      return d[6] ? "R5" : "R6";
   endfunction

   task automatic compare(string tag);
      logic [7:0] e;
      e = exp_read(m_phase, m_data, m_dir, btn_pressed, six_btn_en);
      n_chk++;
      if (rd_data !== e) begin
         n_bad++;
         $display("FAIL %s: rd_data=%02h expected=%02h (phase model %0d)", tag, rd_data, e, m_phase);
      end
   endtask

   // drive at negedge, model at posedge, sample at the following negedge
   task automatic step(logic we, logic sel, logic [7:0] wd, logic [11:0] b,
                       logic six, logic [7:0] lim, string tag);
      bit adv;
      wr_en = we; wr_sel = sel; wr_data = wd; btn_pressed = b;
      six_btn_en = six; idle_limit = lim;
      @(posedge clk);
      adv = six && we && !sel && !m_data[6] && wd[6];
      if (!six) begin
         m_phase = 0; m_idle = 0;
      end else if (adv) begin
         m_phase = (m_phase == 3) ? 0 : m_phase + 1; m_idle = 0;
      end else if (m_phase == 0) begin
         m_idle = 0;
      end else if (m_idle == int'(lim)) begin
         m_phase = 0; m_idle = 0;
      end else begin
         m_idle++;
      end
      if (we) begin
         if (sel) m_dir = wd;
         else     m_data = wd;
      end
      @(negedge clk);
      compare((tag == "") ? auto_tag(m_phase, m_data, six) : tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
      // R3: direction write then data write
      step(1, 1, 8'h00, 12'h000, 1, 8'd200, "R3");
      step(1, 0, 8'h00, 12'h000, 1, 8'd200, "R6");
      // R2: one button in each field
      step(0, 0, 8'h00, 12'h001, 1, 8'd200, "R2");
      step(0, 0, 8'h00, 12'h080, 1, 8'd200, "R2");
      // walk the phases
      step(1, 0, 8'h40, 12'h000, 1, 8'd200, "R5");
      step(1, 0, 8'h40, 12'h000, 1, 8'd200, "R4");
      step(1, 0, 8'h00, 12'h000, 1, 8'd200, "R6");
      step(1, 0, 8'h40, 12'h000, 1, 8'd200, "R5");
      step(1, 0, 8'h00, 12'h000, 1, 8'd200, "R7");
      step(0, 0, 8'h00, 12'h0C0, 1, 8'd200, "R7");
      step(1, 0, 8'h40, 12'h000, 1, 8'd200, "R8");
      step(0, 0, 8'h00, 12'h400, 1, 8'd200, "R8");
      step(0, 0, 8'h00, 12'h900, 1, 8'd200, "R8");
      step(1, 0, 8'h00, 12'h000, 1, 8'd200, "R9");
      step(0, 0, 8'h00, 12'h080, 1, 8'd200, "R9");
      step(1, 0, 8'h40, 12'h000, 1, 8'd200, "R4");
      step(1, 0, 8'h00, 12'h000, 1, 8'd200, "R4");
      // R10: output bits and bit 7
      step(1, 1, 8'h8F, 12'h000, 1, 8'd200, "R10");
      step(1, 0, 8'h85, 12'h000, 1, 8'd200, "R10");
      step(1, 1, 8'h00, 12'h000, 1, 8'd200, "R10");
      step(1, 0, 8'h00, 12'h000, 1, 8'd200, "R10");
      // R11: reach phase 2 low with short timeout, then idle
      step(1, 0, 8'h40, 12'h000, 1, 8'd200, "R11");
      step(1, 0, 8'h00, 12'h000, 1, 8'd200, "R11");
      step(1, 0, 8'h40, 12'h000, 1, 8'd200, "R11");
      step(1, 0, 8'h00, 12'h000, 1, 8'd2,   "R11");
      for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 12'h000, 1, 8'd2, "R11");
      // R12: three-button mode ignores toggles
      for (int i = 0; i < 8; i++) step(1, 0, (i % 2) ? 8'h00 : 8'h40, 12'hF00, 0, 8'd200, "R12");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         logic [7:0] v;
         logic       six;
         r   = $urandom % 8;
         v   = 8'($urandom);
         six = ($urandom % 40) != 0;
         if (r < 5)       step(1, 0, v, 12'($urandom), six, 8'($urandom % 8), "");
         else if (r == 5) step(1, 1, v & 8'($urandom), 12'($urandom), six, 8'($urandom % 8), "");
         else             step(0, 0, v, 12'($urandom), six, 8'($urandom % 8), "");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule